// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Router

This block gathers level-sensitive interrupt lines from peripherals, in one or more banks of 32 lines each, and forwards them to nine core priority inputs. Each line is captured into a status register, qualified by a per-line enable mask, and then steered to one of the nine priority outputs by a 4-bit field that software programs. Any number of lines may share one priority output. That output is high while at least one of the lines mapped to it is both pending and enabled.

Software reaches the block through a simple word-addressed register port. The write strobe takes effect on the clock edge. Reads are combinational from the address. Each bank offers a mask register, four assignment registers, a read-only status register and a wakeup register. Three 16-bit control words sit at the bottom of the map and are stored only. The routing is plain combinational logic fed from registers, so the block has no sequencer and no states. A change of line level or of mask reaches the outputs one clock edge after it is presented.

Top module: `sysirq_router`

## Requirements
- R1: The status bit of each line is that line's input level registered on the rising clock edge. It is 1 after an edge that sees the line high and 0 after an edge that sees it low.
- R2: A line is active only when its status bit and its mask bit are both 1. A line whose mask bit is 0 drives no output.
- R3: Line n of bank k takes its 4-bit priority field from assignment register 4k + n/8, at bits (n mod 8)*4 + 3 down to (n mod 8)*4.
- R4: An active line with field value v (0 to 8) drives `prio_out[v]`, where bit v stands for core level 7+v. Each output bit is the OR of all active lines mapped to it.
- R5: An active line whose field value is 9 to 15 drives no output.
- R6: The status register is read-only. A bus write to it changes neither its read value nor the outputs.
- R7: After reset, mask and status are 0 and wakeup is 0xFFFFFFFF in every bank. The four assignment registers of every bank hold 0x10000000, 0x33322221, 0x66655444 and 0x00000000. The control words are 0.
- R8: The byte offsets are as follows. The control words sit at 0x00, 0x04 and 0x08. Bank k starts at 0x0C + 0x20*k and holds, in order, mask at +0x00, assignment 0 to 3 at +0x04 to +0x10, status at +0x14 and wakeup at +0x18. Bank slot +0x1C is unmapped.
- R9: A read of any unmapped offset returns 0.
- R10: A write to a mask register reroutes on the next cycle. A line that is already pending drives its output as soon as the write edge has passed.
- R11: The wakeup register stores and returns the written word and has no effect on the outputs.
- R12: Each control word stores bits 15:0 of the written data and reads back with bits 31:16 equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NBANK*LINES | Peripheral interrupt levels; bit 32k+n is line n of bank k |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset of the register (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| prio_out | output | LEVELS | Core priority requests; bit v means level 7+v |

## Verification
Two things can land on the same clock edge: a register write, such as a mask, assignment or status write, and a change of the interrupt lines. The bench provokes this with random interleavings from a fixed seed. Each random write uses the edge on which the status register also samples the latest line pattern. After every step the bench compares `prio_out` with a model built from the line levels and the registers it has written. Directed cases cover a write to status while a line is held high, an unmask of an already pending line, out-of-range fields, and two banks driving the same output.

// File: rtl/sysirq_pkg.sv
package sysirq_pkg;
    localparam int WORD_W      = 32;
    localparam int FIELD_W     = 4;
    localparam int FIELDS_PER  = WORD_W / FIELD_W;
    localparam int CTL_W       = 16;
    localparam int CTL_WORDS   = 3;
    localparam int BANK_WORDS  = 8;

    typedef enum logic [2:0] {
        SL_MASK = 3'd0,
        SL_ASG0 = 3'd1,
        SL_ASG1 = 3'd2,
        SL_ASG2 = 3'd3,
        SL_ASG3 = 3'd4,
        SL_STAT = 3'd5,
        SL_WAKE = 3'd6,
        SL_NONE = 3'd7
    } slot_e;

    function automatic logic [WORD_W-1:0] asg_reset(input int r);
        case (r % 4)
            0:       return 32'h1000_0000;
            1:       return 32'h3332_2221;
            2:       return 32'h6665_5444;
            default: return 32'h0000_0000;
        endcase
    endfunction
endpackage

// File: rtl/sysirq_route.sv
module sysirq_route
    import sysirq_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int LEVELS = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LINES-1:0]         active_i,
    input  logic [LINES*FIELD_W-1:0] fields_i,
    output logic [LEVELS-1:0]        hit_o
);
    always_comb begin
        hit_o = '0;
        for (int j = 0; j < LEVELS; j++) begin
            for (int n = 0; n < LINES; n++) begin
                if (active_i[n] && (int'(fields_i[n*FIELD_W +: FIELD_W]) == j))
                    hit_o[j] = 1'b1;
            end
        end
    end

    // R2: no active line, no request
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i == '0) |-> (hit_o == '0));

    // R4: each request needs at least one distinct active line
    p_hits_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit_o) <= $countones(active_i));
endmodule

// File: rtl/sysirq_bank.sv
module sysirq_bank
    import sysirq_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int LEVELS = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   irq_i,
    input  logic               sel_i,
    input  slot_e              slot_i,
    input  logic               we_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [WORD_W-1:0]  rdata_o,
    output logic [LEVELS-1:0]  hit_o
);
    localparam int ASG_REGS = LINES / FIELDS_PER;

    logic [LINES-1:0]           stat_q;
    logic [LINES-1:0]           mask_q;
    logic [WORD_W-1:0]          wake_q;
    logic [WORD_W-1:0]          asg_q [ASG_REGS];
    logic [LINES*FIELD_W-1:0]   fields;
    logic                       wr;

    assign wr = sel_i && we_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
            wake_q <= '1;
            for (int r = 0; r < ASG_REGS; r++) asg_q[r] <= asg_reset(r);
        end else begin
            stat_q <= irq_i;
            if (wr && slot_i == SL_MASK) mask_q <= wdata_i[LINES-1:0];
            if (wr && slot_i == SL_WAKE) wake_q <= wdata_i;
            for (int r = 0; r < ASG_REGS; r++)
                if (wr && slot_i == slot_e'(r + 1)) asg_q[r] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (slot_i)
            SL_MASK: rdata_o = WORD_W'(mask_q);
            SL_STAT: rdata_o = WORD_W'(stat_q);
            SL_WAKE: rdata_o = wake_q;
            SL_NONE: rdata_o = '0;
            default: begin
                for (int r = 0; r < ASG_REGS; r++)
                    if (slot_i == slot_e'(r + 1)) rdata_o = asg_q[r];
            end
        endcase
    end

    for (genvar n = 0; n < LINES; n++) begin : g_field
        assign fields[n*FIELD_W +: FIELD_W] =
            asg_q[n / FIELDS_PER][(n % FIELDS_PER)*FIELD_W +: FIELD_W];
    end

    sysirq_route #(.LINES(LINES), .LEVELS(LEVELS)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (stat_q & mask_q),
        .fields_i (fields),
        .hit_o    (hit_o)
    );

    // R1: status is the line level from the previous edge
    p_status_tracks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stat_q == $past(irq_i)));

    // R10: a mask write lands on the next cycle
    p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && slot_i == SL_MASK) |=> (mask_q == $past(wdata_i[LINES-1:0])));

    // R11: wakeup keeps what was written
    p_wake_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && slot_i == SL_WAKE) |=> (wake_q == $past(wdata_i)));
endmodule

// File: rtl/sysirq_router.sv
module sysirq_router
    import sysirq_pkg::*;
#(
    parameter int NBANK  = 2,
    parameter int LINES  = 32,
    parameter int LEVELS = 9,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NBANK*LINES-1:0]  irq_in,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    output logic [LEVELS-1:0]       prio_out
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]   widx;
    logic [CTL_W-1:0]   ctl_q [CTL_WORDS];
    logic [WORD_W-1:0]  ctl_rd;
    logic [NBANK-1:0]   bsel;
    logic [WORD_W-1:0]  brd [NBANK];
    logic [LEVELS-1:0]  bhit [NBANK];

    assign widx = bus_addr[ADDR_W-1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < CTL_WORDS; c++) ctl_q[c] <= '0;
        end else begin
            for (int c = 0; c < CTL_WORDS; c++)
                if (bus_we && int'(widx) == c) ctl_q[c] <= bus_wdata[CTL_W-1:0];
        end
    end

    always_comb begin
        ctl_rd = '0;
        for (int c = 0; c < CTL_WORDS; c++)
            if (int'(widx) == c) ctl_rd = WORD_W'(ctl_q[c]);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int BASE = CTL_WORDS + b * BANK_WORDS;
        logic [IDX_W-1:0] off;
        assign off     = widx - IDX_W'(BASE);
        assign bsel[b] = (int'(widx) >= BASE) && (int'(widx) < BASE + BANK_WORDS);

        sysirq_bank #(.LINES(LINES), .LEVELS(LEVELS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq_i   (irq_in[b*LINES +: LINES]),
            .sel_i   (bsel[b]),
            .slot_i  (slot_e'(off[2:0])),
            .we_i    (bus_we),
            .wdata_i (bus_wdata),
            .rdata_o (brd[b]),
            .hit_o   (bhit[b])
        );
    end

    always_comb begin
        bus_rdata = ctl_rd;
        prio_out  = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (bsel[b]) bus_rdata = bus_rdata | brd[b];
            prio_out = prio_out | bhit[b];
        end
    end

    // R12: control words read back only 16 bits
    p_ctl_upper_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(widx) < CTL_WORDS) |-> (bus_rdata[WORD_W-1:CTL_W] == '0));
endmodule

// File: tb/sysirq_router_tb.sv
`timescale 1ns/1ps
module sysirq_router_tb;
    localparam int NB = 2;
    localparam int NL = 32;
    localparam int LV = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB*NL-1:0]  irq_in = '0;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [LV-1:0]     prio_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] mask_m [NB];
    logic [31:0] asg_m  [NB*4];

    always #4 clk = ~clk;

    sysirq_router #(.NBANK(NB), .LINES(NL), .LEVELS(LV), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prio_out(prio_out)
    );

    function automatic logic [7:0] reg_at(input int bank, input int slot);
        return 8'((3 + 8*bank + slot) * 4);
    endfunction

    function automatic logic [LV-1:0] exp_out();
        logic [LV-1:0] e = '0;
        for (int b = 0; b < NB; b++)
            for (int n = 0; n < NL; n++)
                if (irq_in[b*NL+n] && mask_m[b][n]) begin
                    int v = int'(asg_m[b*4 + n/8][(n%8)*4 +: 4]);
                    if (v < LV) e[v] = 1'b1;
                end
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        int w = int'(a) / 4;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (w >= 3 && (w - 3) / 8 < NB) begin
            int b = (w - 3) / 8;
            int s = (w - 3) % 8;
            if (s == 0) mask_m[b] = d;
            else if (s >= 1 && s <= 4) asg_m[b*4 + s - 1] = d;
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string req);
        bus_addr = a;
        #1;
        chk(bus_rdata === e, req, bus_rdata, e);
    endtask

    task automatic out_chk(input string req);
        logic [LV-1:0] e = exp_out();
        chk(prio_out === e, req, 32'(prio_out), 32'(e));
    endtask

    task automatic set_irq(input logic [NB*NL-1:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int b = 0; b < NB; b++) begin
            mask_m[b] = '0;
            asg_m[b*4+0] = 32'h1000_0000;
            asg_m[b*4+1] = 32'h3332_2221;
            asg_m[b*4+2] = 32'h6665_5444;
            asg_m[b*4+3] = 32'h0000_0000;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 / R8: reset values at their offsets
        rd_chk(8'h00, 32'h0, "R7 ctl0");
        rd_chk(8'h04, 32'h0, "R7 ctl1");
        rd_chk(8'h08, 32'h0, "R7 ctl2");
        for (int b = 0; b < NB; b++) begin
            rd_chk(reg_at(b, 0), 32'h0, "R7 R8 mask");
            rd_chk(reg_at(b, 1), 32'h1000_0000, "R7 R8 asg0");
            rd_chk(reg_at(b, 2), 32'h3332_2221, "R7 R8 asg1");
            rd_chk(reg_at(b, 3), 32'h6665_5444, "R7 R8 asg2");
            rd_chk(reg_at(b, 4), 32'h0, "R7 R8 asg3");
            rd_chk(reg_at(b, 5), 32'h0, "R7 R8 status");
            rd_chk(reg_at(b, 6), 32'hFFFF_FFFF, "R7 R8 wake");
        end
        chk(prio_out === '0, "R7 outputs", 32'(prio_out), 0);

        // R9: unmapped offsets
        rd_chk(reg_at(0, 7), 32'h0, "R9 bank0 gap");
        rd_chk(reg_at(1, 7), 32'h0, "R9 bank1 gap");
        rd_chk(8'hFC, 32'h0, "R9 top");

        // R12: 16-bit control words
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, 32'h0000_FFFF, "R12 ctl1");
        wr(8'h08, 32'h1234_A5A5);
        rd_chk(8'h08, 32'h0000_A5A5, "R12 ctl2");

        // R2 then R10: pending line masked, then unmasked
        set_irq(64'h1);
        chk(prio_out === '0, "R2 masked line", 32'(prio_out), 0);
        rd_chk(reg_at(0, 5), 32'h1, "R1 status high");
        wr(reg_at(0, 0), 32'h1);
        chk(prio_out === 9'h001, "R10 unmask", 32'(prio_out), 32'h1);

        // R6: status write ignored
        wr(reg_at(0, 5), 32'h0);
        rd_chk(reg_at(0, 5), 32'h1, "R6 status ro");
        chk(prio_out === 9'h001, "R6 outputs", 32'(prio_out), 32'h1);

        // R11: wakeup stored, no routing effect
        wr(reg_at(0, 6), 32'h0);
        rd_chk(reg_at(0, 6), 32'h0, "R11 wake readback");
        chk(prio_out === 9'h001, "R11 no effect", 32'(prio_out), 32'h1);

        // R5: out-of-range field
        wr(reg_at(0, 1), 32'h0000_000F);
        chk(prio_out === '0, "R5 field F", 32'(prio_out), 0);
        wr(reg_at(0, 1), 32'h0000_0009);
        chk(prio_out === '0, "R5 field 9", 32'(prio_out), 0);
        wr(reg_at(0, 1), 32'h0000_0008);
        chk(prio_out === 9'h100, "R4 field 8", 32'(prio_out), 32'h100);

        // R3 / R4: bank1 line 9 and bank0 line 1 share level 5
        wr(reg_at(0, 1), 32'h0000_005F);
        wr(reg_at(0, 0), 32'h3);
        wr(reg_at(1, 2), 32'h0000_0050);
        wr(reg_at(1, 0), 32'h200);
        set_irq(64'h0000_0200_0000_0002);
        chk(prio_out === 9'h020, "R3 R4 shared", 32'(prio_out), 32'h20);
        set_irq(64'h0000_0000_0000_0002);
        chk(prio_out === 9'h020, "R4 OR one left", 32'(prio_out), 32'h20);
        set_irq(64'h0000_0200_0000_0000);
        chk(prio_out === 9'h020, "R3 bank1 alone", 32'(prio_out), 32'h20);
        set_irq('0);
        chk(prio_out === '0, "R1 fall", 32'(prio_out), 0);

        // random interleaving of writes and line changes
        for (int it = 0; it < 400; it++) begin
            int act = int'($urandom % 4);
            int b = int'($urandom % NB);
            case (act)
                0: wr(reg_at(b, 1 + int'($urandom % 4)), $urandom);
                1: wr(reg_at(b, 0), $urandom | $urandom);
                2: wr(reg_at(b, 5), $urandom);
                default: set_irq({$urandom, $urandom});
            endcase
            out_chk("R2 R3 R4 R5 random");
            if (it % 8 == 0)
                rd_chk(reg_at(b, 5), irq_in[b*NL +: NL], "R1 R6 status random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule